// File: doc/BRIEF.md
# Status-Flag Branch and Bit-Set Unit

This block keeps an 8-bit processor status register. It runs two families of instructions through one shared bit-selection path. The first family is relative branches that test a single status bit for set or for clear. The second family is instructions that force a single status bit to one or to zero. Each instruction carries a 3-bit field that picks the status bit. The many named branch and flag mnemonics an assembler offers therefore reduce to four hardware opcodes. Two names that share an encoding behave the same in every way. For example, "branch if carry clear" and "branch if unsigned same or higher" are both the clear-test branch with selector 0.

Each cycle the block takes an instruction word, a valid strobe and the current program counter. It reports three things, all as combinational outputs:

- whether the branch is taken, based on the status register as it stands;
- the relative branch target;
- the registered status value.

A set or clear updates the register on the clock edge, so a branch in the next cycle already sees the new value. Flag generation by an ALU, instruction fetch and pipeline flushing belong to other blocks.

Top module: `flagbr_unit`

## Requirements
- R1: While reset is active, and right after it, the status register reads 0x00. With the valid strobe low, no branch is reported.
- R2: A valid word whose bits 15..10 are 111101 reports a taken branch exactly when the selected status bit is 0. This holds for every selector value, including selector 0 (the carry test), which two assembler names share.
- R3: A valid word whose bits 15..10 are 111100 reports a taken branch exactly when the selected status bit is 1.
- R4: For branches the selector sits in bits 2..0. Values 0 to 7 pick status bits 0 to 7 in this order: carry, zero, negative, overflow, sign, half-carry, transfer, global interrupt enable.
- R5: The branch target equals pcIn + 1 + offset, wrapped to the program-counter width. The offset is the 7-bit two's-complement field in bits 9..3.
- R6: The valid word 1001_0100_0sss_1000 sets status bit sss, taken from bits 6..4, on the next clock edge. All other bits keep their values.
- R7: The valid word 1001_0100_1sss_1000 clears status bit sss, taken from bits 6..4, on the next clock edge. All other bits keep their values.
- R8: A status change made by a set or clear instruction decides the branch outcome of a valid branch issued in the very next cycle.
- R9: While the valid strobe is low, no branch is reported and the status register holds, whatever the instruction word is.
- R10: A valid word that matches none of the four opcodes reports no branch and leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | The instruction word is valid this cycle |
| instrWord | input | 16 | Instruction word |
| pcIn | input | PC_W | Program counter of the current instruction |
| branchTaken | output | 1 | The branch is taken this cycle |
| branchTarget | output | PC_W | Relative branch destination |
| statusOut | output | 8 | Current status register |

## Verification
The bench builds the unit with PC_W = 8. With that width, random program counters near both ends of the address space, combined with offsets of -64 and +63, reach target wraparound in both directions often. This exercises the modular adder at its boundary rather than only in the middle of the range. The 8-bit status register is small enough that a random mix of set and clear words visits every selector against both bit values many times. This covers each branch polarity with every selector, including next-cycle visibility after an update.

// File: rtl/flagbr_pkg.sv
package flagbr_pkg;

  localparam int STAT_W = 8;
  localparam int SEL_W  = $clog2(STAT_W);
  localparam int WORD_W = 16;
  localparam int OFFS_W = 7;

  // branch opcodes in bits 15..10
  localparam logic [5:0] BR_ON_CLEAR = 6'b111101;
  localparam logic [5:0] BR_ON_SET   = 6'b111100;
  // flag opcodes: fixed bits 15..8, polarity bit 7, fixed low nibble
  localparam logic [7:0] FLAG_HI     = 8'b1001_0100;
  localparam logic [3:0] FLAG_LO     = 4'b1000;

  typedef struct packed {
    logic             brEn;      // a branch test is requested
    logic             brWantSet; // branch when selected bit is 1
    logic             doSet;
    logic             doClear;
    logic [SEL_W-1:0] sel;       // status bit selector
  } ctrlStrobes_t;

endpackage

// File: rtl/flagbr_ctrl.sv
module flagbr_ctrl
  import flagbr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  output ctrlStrobes_t      strobes
);

  logic isBrClear, isBrSet, isFlagOp, isBranch;

  always_comb begin
    isBrClear = (instrWord[15:10] == BR_ON_CLEAR);
    isBrSet   = (instrWord[15:10] == BR_ON_SET);
    isFlagOp  = (instrWord[15:8] == FLAG_HI) && (instrWord[3:0] == FLAG_LO);
    isBranch  = isBrClear || isBrSet;

    strobes.brEn      = instrValid && isBranch;
    strobes.brWantSet = isBrSet;
    strobes.doSet     = instrValid && isFlagOp && !instrWord[7];
    strobes.doClear   = instrValid && isFlagOp &&  instrWord[7];
    strobes.sel       = isBranch ? instrWord[SEL_W-1:0] : instrWord[4 +: SEL_W];
  end

  // R9: nothing is requested while the strobe is low
  assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !(strobes.brEn || strobes.doSet || strobes.doClear));

  // R10: at most one action per word
  assert_one_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.brEn, strobes.doSet, strobes.doClear}));

endmodule

// File: rtl/flagbr_dp.sv
module flagbr_dp
  import flagbr_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [OFFS_W-1:0] offset,
  input  logic [PC_W-1:0]   pcIn,
  output logic              branchTaken,
  output logic [PC_W-1:0]   branchTarget,
  output logic [STAT_W-1:0] statusOut
);

  localparam int EXT_W = PC_W - OFFS_W;

  logic [STAT_W-1:0] statusQ;
  logic [PC_W-1:0]   offsetExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (strobes.doSet) begin
      statusQ[strobes.sel] <= 1'b1;
    end else if (strobes.doClear) begin
      statusQ[strobes.sel] <= 1'b0;
    end
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign offsetExt = {{EXT_W{offset[OFFS_W-1]}}, offset};
    end else begin : g_trunc
      assign offsetExt = offset[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    branchTaken  = strobes.brEn && (statusQ[strobes.sel] == strobes.brWantSet);
    branchTarget = pcIn + PC_W'(1) + offsetExt;
  end

  assign statusOut = statusQ;

  // R6: the selected bit reads one after a set
  assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doSet |=> statusQ[$past(strobes.sel)]);

  // R7: the selected bit reads zero after a clear
  assert_clear_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doClear |=> !statusQ[$past(strobes.sel)]);

  // R9/R10: no update request means the register holds
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.doSet || strobes.doClear) |=> $stable(statusQ));

endmodule

// File: rtl/flagbr_unit.sv
module flagbr_unit
  import flagbr_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  input  logic [PC_W-1:0]   pcIn,
  output logic              branchTaken,
  output logic [PC_W-1:0]   branchTarget,
  output logic [7:0]        statusOut
);

  ctrlStrobes_t strobes;

  flagbr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .strobes    (strobes)
  );

  flagbr_dp #(.PC_W(PC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .offset       (instrWord[3 +: OFFS_W]),
    .pcIn         (pcIn),
    .branchTaken  (branchTaken),
    .branchTarget (branchTarget),
    .statusOut    (statusOut)
  );

  // R2/R3/R9: a taken branch needs a valid word
  assert_taken_needs_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> instrValid);

endmodule

// File: tb/flagbr_unit_tb.sv
module flagbr_unit_tb;

  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          instrValid;
  logic [15:0]   instrWord;
  logic [PW-1:0] pcIn;
  logic          branchTaken;
  logic [PW-1:0] branchTarget;
  logic [7:0]    statusOut;

  int total = 0;
  int bad = 0;
  logic [7:0] expStat;

  always #5 clk = ~clk;

  flagbr_unit #(.PC_W(PW)) u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .pcIn(pcIn), .branchTaken(branchTaken), .branchTarget(branchTarget),
    .statusOut(statusOut)
  );

  function automatic logic isBr(input logic [15:0] w);
    return (w[15:10] == 6'b111101) || (w[15:10] == 6'b111100);
  endfunction

  function automatic logic expTaken(input logic [15:0] w, input logic v, input logic [7:0] s);
    if (!v) return 1'b0;
    if (w[15:10] == 6'b111101) return !s[w[2:0]];
    if (w[15:10] == 6'b111100) return s[w[2:0]];
    return 1'b0;
  endfunction

  function automatic logic [PW-1:0] expTarget(input logic [15:0] w, input logic [PW-1:0] pc);
    int off;
    off = w[9] ? int'(w[9:3]) - 128 : int'(w[9:3]);
    return PW'(int'(pc) + 1 + off);
  endfunction

  function automatic logic [7:0] nextStat(input logic [15:0] w, input logic v, input logic [7:0] s);
    logic [7:0] r;
    r = s;
    if (v && w[15:8] == 8'b1001_0100 && w[3:0] == 4'b1000) r[w[6:4]] = !w[7];
    return r;
  endfunction

  function automatic logic [15:0] brWord(input logic onSet, input logic [2:0] sel, input logic [6:0] off);
    return {5'b11110, !onSet, off, sel};
  endfunction

  function automatic logic [15:0] flWord(input logic clr, input logic [2:0] sel);
    return {8'b1001_0100, clr, sel, 4'b1000};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic step(input logic [15:0] w, input logic v, input logic [PW-1:0] pc, input string req);
    logic et;
    instrWord = w; instrValid = v; pcIn = pc;
    #1;
    et = expTaken(w, v, expStat);
    check(branchTaken == et, {req, " taken"}, 32'(branchTaken), 32'(et));
    if (isBr(w)) check(branchTarget == expTarget(w, pc), "R5 target",
                       32'(branchTarget), 32'(expTarget(w, pc)));
    @(posedge clk);
    expStat = nextStat(w, v, expStat);
    #1;
    check(statusOut == expStat, {req, " status"}, 32'(statusOut), 32'(expStat));
    @(negedge clk);
  endtask

  initial begin
    #(10 * 150000);
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; instrValid = 1'b0; instrWord = '0; pcIn = '0;
    expStat = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(statusOut == 8'h00, "R1 reset status", 32'(statusOut), 0);
    check(branchTaken == 1'b0, "R1 reset branch", 32'(branchTaken), 0);
    rstN = 1'b1;
    step(flWord(1'b0, 3'd0), 1'b0, 8'h10, "R1");

    // R4: walk selectors in order, set then test set and clear variants
    for (int k = 0; k < 8; k++) begin
      step(brWord(1'b1, 3'(k), 7'd5), 1'b1, 8'h20, "R3 before set");
      step(flWord(1'b0, 3'(k)), 1'b1, 8'h20, "R6");
      step(brWord(1'b1, 3'(k), 7'd5), 1'b1, 8'h21, "R8 R4 set test");
      step(brWord(1'b0, 3'(k), 7'd5), 1'b1, 8'h22, "R2 R4 clear test");
    end
    check(statusOut == 8'hFF, "R4 all set", 32'(statusOut), 32'hFF);
    // R2 alias: carry clear / same-or-higher share selector 0
    step(flWord(1'b1, 3'd0), 1'b1, 8'h30, "R7");
    step(brWord(1'b0, 3'd0, 7'h7F), 1'b1, 8'h31, "R2 R8 carry clear alias");
    // R5 wraparound
    step(brWord(1'b0, 3'd0, 7'h40), 1'b1, 8'h00, "R5 wrap down");
    step(brWord(1'b0, 3'd0, 7'h3F), 1'b1, 8'hFF, "R5 wrap up");
    // R9: valid low ignores a clear and a branch
    step(flWord(1'b1, 3'd7), 1'b0, 8'h40, "R9 clear ignored");
    step(brWord(1'b1, 3'd7, 7'd1), 1'b0, 8'h41, "R9 branch ignored");
    // R10: near-miss words
    step(16'h9479, 1'b1, 8'h50, "R10 bad low nibble");
    step(16'h9578, 1'b1, 8'h50, "R10 bad high byte");
    step(16'hF800, 1'b1, 8'h50, "R10 other branch space");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      logic v;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 40) w = brWord(1'($urandom), 3'($urandom), 7'($urandom));
      else if (r < 80) w = flWord(1'($urandom), 3'($urandom));
      else w = 16'($urandom);
      v = ($urandom_range(0, 99) < 85);
      step(w, v, PW'($urandom), "R2 R3 R6 R7 R9 R10 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule